// File: doc/BRIEF.md
# Bit-Compare Network Route Selector

This block makes the routing decision for one input of a small on-chip network switch. A message is a run of tokens. Its first token carries the destination node ID. The block compares that ID with the switch's own node ID. When the two are equal, the message goes to the local core endpoint. When they differ, the block finds the most significant bit position where they disagree. A per-bit table turns that position into a direction code. A per-direction mask lists the outbound links that may carry traffic in that direction. Scanning from the highest bit down gives dimension-ordered routing.

Within a direction's link set, a link is granted round-robin, and only links that the rest of the switch reports as available are eligible. The granted target is then reserved for this input. Every following token goes to the same target without another ID compare. The reservation ends once a closing control token has passed. A message that never sends one keeps its route, which forms a permanent stream. While no eligible link exists, the header waits with `in_ready` low.

The direction table and the link masks are written through a small configuration port. Link physical encoding, credit flow control and payload buffering are handled elsewhere in the switch.

Top module: `rs_route_sel`

## Requirements
- R1: After reset, `out_valid` is 0 and `route_hold` is all zeros.
- R2: A header whose ID equals `node_id` is routed to the local endpoint, which is bit LINKS of `out_port`. Every output token has exactly one `out_port` bit set, where bit k below LINKS names link k.
- R3: A header whose ID differs from `node_id` uses the direction table entry indexed by the highest differing bit position. Entry p is written with `cfg_we`=1, `cfg_tbl`=0, `cfg_addr`=p and the code in `cfg_wdata[3:0]`. Lower differing bits have no effect.
- R4: The link set of direction d is written with `cfg_tbl`=1, `cfg_addr`=d and `cfg_wdata`, where bit k enables link k. A set with one link always routes to that link. Direction codes of NDIR and above have an empty set.
- R5: Each direction grants round-robin, starting at the link after the one it last granted and wrapping around. After reset, the first grant in a direction goes to its lowest-numbered eligible link.
- R6: A link is granted only if its `link_avail` bit is 1 in the cycle the header is accepted.
- R7: If a routed header has no eligible link, `in_ready` stays 0 and no token is output. The header is accepted as soon as a link becomes eligible.
- R8: `route_hold` shows the reserved target from the cycle after the header is accepted. It clears in the cycle after a close token is accepted. A close token has `in_ctrl`=1 and `in_data[7:0]`=8'h01.
- R9: Each accepted token appears on `out_data`/`out_ctrl` one cycle later, unchanged. Tokens after the header follow the reserved target whatever their content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | ID_W | This switch's own node ID |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tbl | input | 1 | 0: direction table entry, 1: direction link mask |
| cfg_addr | input | $clog2(ID_W) | Bit position or direction code |
| cfg_wdata | input | LINKS | Write data |
| link_avail | input | LINKS | Links currently free elsewhere in the switch |
| in_valid | input | 1 | Input token valid |
| in_data | input | ID_W | Input token (header: destination ID) |
| in_ctrl | input | 1 | Input token is a control token |
| in_ready | output | 1 | Token accepted this cycle when valid |
| out_valid | output | 1 | Output token valid |
| out_data | output | ID_W | Forwarded token |
| out_ctrl | output | 1 | Forwarded control flag |
| out_port | output | LINKS+1 | One-hot target: links, then local |
| route_hold | output | LINKS+1 | Target reserved by the open message |

## Verification
`in_ready` is combinational, so it answers a header in the same cycle it is presented. The bench reads it one time unit after driving inputs on the falling edge. Each forwarded token and each change of `route_hold` is due one clock after the accepting rising edge, so the bench checks them on the falling edge that follows. Stalls are held for several cycles, with `in_ready` and `out_valid` checked on every one of them. The release of a stall is timed from the configuration write that lands at a rising edge.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int DIR_W = 4;
  typedef enum logic {ST_IDLE, ST_ROUTED} rs_state_e;
endpackage

// File: rtl/rs_first_diff.sv
module rs_first_diff #(
  parameter int W = 16
) (
  input  logic [W-1:0]          a,
  input  logic [W-1:0]          b,
  output logic                  hit,
  output logic [$clog2(W)-1:0]  idx
);
  localparam int IW = $clog2(W);
  logic [W-1:0] x;

  always_comb begin
    x   = a ^ b;
    hit = |x;
    idx = '0;
    // ascending scan: the last match is the most significant differing bit
    for (int i = 0; i < W; i++) begin
      if (x[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/rs_cfg_regs.sv
module rs_cfg_regs #(
  parameter int ID_W  = 16,
  parameter int NDIR  = 10,
  parameter int LINKS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic                     cfg_tbl,
  input  logic [$clog2(ID_W)-1:0]  cfg_addr,
  input  logic [LINKS-1:0]         cfg_wdata,
  input  logic [$clog2(ID_W)-1:0]  rd_bit,
  output logic [rs_pkg::DIR_W-1:0] rd_dir,
  output logic                     rd_dir_ok,
  output logic [LINKS-1:0]         rd_mask
);
  import rs_pkg::*;
  localparam int BW = $clog2(ID_W);

  logic [DIR_W-1:0] dir_tbl [ID_W];
  logic [LINKS-1:0] mask_q  [NDIR];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ID_W; i++) dir_tbl[i] <= '0;
      for (int d = 0; d < NDIR; d++) mask_q[d] <= '0;
    end else if (cfg_we) begin
      if (!cfg_tbl) begin
        for (int i = 0; i < ID_W; i++)
          if (cfg_addr == BW'(i)) dir_tbl[i] <= cfg_wdata[DIR_W-1:0];
      end else begin
        for (int d = 0; d < NDIR; d++)
          if (cfg_addr == BW'(d)) mask_q[d] <= cfg_wdata;
      end
    end
  end

  always_comb begin
    rd_dir = '0;
    for (int i = 0; i < ID_W; i++)
      if (rd_bit == BW'(i)) rd_dir = dir_tbl[i];
    rd_dir_ok = 1'b0;
    rd_mask   = '0;
    for (int d = 0; d < NDIR; d++) begin
      if (rd_dir == DIR_W'(d)) begin
        rd_dir_ok = 1'b1;
        rd_mask   = mask_q[d];
      end
    end
  end
endmodule

// File: rtl/rs_rr_pick.sv
module rs_rr_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0]          req,
  input  logic [$clog2(N)-1:0]  last,
  output logic                  found,
  output logic [$clog2(N)-1:0]  pick
);
  localparam int LW = $clog2(N);

  always_comb begin
    found = 1'b0;
    pick  = last;
    for (int off = 1; off <= N; off++) begin
      if (!found && req[(int'(last) + off) % N]) begin
        found = 1'b1;
        pick  = LW'((int'(last) + off) % N);
      end
    end
  end
endmodule

// File: rtl/rs_route_sel.sv
module rs_route_sel #(
  parameter int         ID_W       = 16,
  parameter int         LINKS      = 8,
  parameter int         NDIR       = 10,
  parameter logic [7:0] CLOSE_CODE = 8'h01
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ID_W-1:0]          node_id,
  input  logic                     cfg_we,
  input  logic                     cfg_tbl,
  input  logic [$clog2(ID_W)-1:0]  cfg_addr,
  input  logic [LINKS-1:0]         cfg_wdata,
  input  logic [LINKS-1:0]         link_avail,
  input  logic                     in_valid,
  input  logic [ID_W-1:0]          in_data,
  input  logic                     in_ctrl,
  output logic                     in_ready,
  output logic                     out_valid,
  output logic [ID_W-1:0]          out_data,
  output logic                     out_ctrl,
  output logic [LINKS:0]           out_port,
  output logic [LINKS:0]           route_hold
);
  import rs_pkg::*;
  localparam int BW    = $clog2(ID_W);
  localparam int LW    = $clog2(LINKS);
  localparam int NPORT = LINKS + 1;

  rs_state_e          state_q;
  logic [NPORT-1:0]   route_q;
  logic [LW-1:0]      ptr_q [NDIR];

  logic               diff_hit;
  logic [BW-1:0]      diff_bit;
  logic [DIR_W-1:0]   dir;
  logic               dir_ok;
  logic [LINKS-1:0]   dir_mask;
  logic [LINKS-1:0]   req;
  logic [LW-1:0]      ptr_sel;
  logic               rr_found;
  logic [LW-1:0]      rr_pick;
  logic               can_route;
  logic [NPORT-1:0]   grant_vec;
  logic               fire;
  logic               is_close;

  rs_first_diff #(.W(ID_W)) diff_i (
    .a(in_data), .b(node_id), .hit(diff_hit), .idx(diff_bit)
  );

  rs_cfg_regs #(.ID_W(ID_W), .NDIR(NDIR), .LINKS(LINKS)) cfg_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_bit(diff_bit),
    .rd_dir(dir), .rd_dir_ok(dir_ok), .rd_mask(dir_mask)
  );

  always_comb begin
    ptr_sel = '0;
    for (int d = 0; d < NDIR; d++)
      if (dir == DIR_W'(d)) ptr_sel = ptr_q[d];
  end

  assign req = dir_mask & link_avail;

  rs_rr_pick #(.N(LINKS)) rr_i (
    .req(req), .last(ptr_sel), .found(rr_found), .pick(rr_pick)
  );

  always_comb begin
    grant_vec = '0;
    if (!diff_hit) grant_vec[LINKS] = 1'b1;
    else           grant_vec[rr_pick] = 1'b1;
  end

  assign can_route = !diff_hit || rr_found;
  assign in_ready  = (state_q == ST_IDLE) ? can_route : 1'b1;
  assign fire      = in_valid && in_ready;
  assign is_close  = in_ctrl && (in_data[7:0] == CLOSE_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      route_q   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ctrl  <= 1'b0;
      out_port  <= '0;
      for (int d = 0; d < NDIR; d++) ptr_q[d] <= LW'(LINKS - 1);
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_data <= in_data;
        out_ctrl <= in_ctrl;
        if (state_q == ST_IDLE) begin
          out_port <= grant_vec;
          if (diff_hit && dir_ok) begin
            for (int d = 0; d < NDIR; d++)
              if (dir == DIR_W'(d)) ptr_q[d] <= rr_pick;
          end
          if (is_close) begin
            route_q <= '0;
          end else begin
            route_q <= grant_vec;
            state_q <= ST_ROUTED;
          end
        end else begin
          out_port <= route_q;
          if (is_close) begin
            route_q <= '0;
            state_q <= ST_IDLE;
          end
        end
      end
    end
  end

  assign route_hold = route_q;
endmodule

// File: rtl/rs_route_sel_chk.sv
module rs_route_sel_chk #(
  parameter int         ID_W       = 16,
  parameter int         LINKS      = 8,
  parameter logic [7:0] CLOSE_CODE = 8'h01
) (
  input logic             clk,
  input logic             rst,
  input logic [LINKS-1:0] link_avail,
  input logic             in_valid,
  input logic [ID_W-1:0]  in_data,
  input logic             in_ctrl,
  input logic             in_ready,
  input logic             out_valid,
  input logic [ID_W-1:0]  out_data,
  input logic [LINKS:0]   out_port,
  input logic [LINKS:0]   route_hold
);
  logic acc;
  logic acc_close;
  assign acc       = in_valid && in_ready;
  assign acc_close = acc && in_ctrl && (in_data[7:0] == CLOSE_CODE);

  assert_one_target_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(out_port) == 1);

  assert_hold_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(route_hold));

  assert_hold_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (|route_hold && !acc_close) |=> $stable(route_hold));

  assert_follow_route_R9: assert property (@(posedge clk) disable iff (rst)
    (acc && |route_hold) |=> (out_port == $past(route_hold)));

  assert_pass_data_R9: assert property (@(posedge clk) disable iff (rst)
    acc |=> (out_valid && out_data == $past(in_data)));

  assert_stall_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (route_hold == '0 && in_valid && !in_ready) |=> !out_valid);

  assert_only_avail_R6: assert property (@(posedge clk) disable iff (rst)
    (acc && route_hold == '0) |=> ((out_port[LINKS-1:0] & ~$past(link_avail)) == '0));
endmodule

bind rs_route_sel rs_route_sel_chk #(
  .ID_W(ID_W), .LINKS(LINKS), .CLOSE_CODE(CLOSE_CODE)
) chk_i (
  .clk(clk), .rst(rst), .link_avail(link_avail), .in_valid(in_valid),
  .in_data(in_data), .in_ctrl(in_ctrl), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data), .out_port(out_port),
  .route_hold(route_hold)
);

// File: tb/rs_route_sel_tb.sv
module rs_route_sel_tb_top;
  localparam int ID_W  = 16;
  localparam int LINKS = 8;
  localparam int NDIR  = 10;
  localparam logic [15:0] ME = 16'hA5C3;
  localparam logic [8:0]  LOCAL = 9'h100;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [15:0]      node_id = ME;
  logic             cfg_we = 1'b0;
  logic             cfg_tbl = 1'b0;
  logic [3:0]       cfg_addr = '0;
  logic [7:0]       cfg_wdata = '0;
  logic [7:0]       link_avail = 8'hFF;
  logic             in_valid = 1'b0;
  logic [15:0]      in_data = '0;
  logic             in_ctrl = 1'b0;
  logic             in_ready;
  logic             out_valid;
  logic [15:0]      out_data;
  logic             out_ctrl;
  logic [8:0]       out_port;
  logic [8:0]       route_hold;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rs_route_sel #(.ID_W(ID_W), .LINKS(LINKS), .NDIR(NDIR)) dut_i (
    .clk(clk), .rst(rst), .node_id(node_id), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .link_avail(link_avail),
    .in_valid(in_valid), .in_data(in_data), .in_ctrl(in_ctrl), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ctrl(out_ctrl),
    .out_port(out_port), .route_hold(route_hold)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic tbl, input logic [3:0] addr, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_tbl = tbl; cfg_addr = addr; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // starts and ends on a falling edge; output checked one clock after acceptance
  task automatic send_tok(input logic [15:0] d, input logic c, input logic [8:0] exp_port, input string req);
    in_valid = 1'b1; in_data = d; in_ctrl = c;
    #1;
    while (!in_ready) begin
      @(posedge clk); @(negedge clk); #1;
    end
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, {req, " valid"}, 32'(out_valid), 1);
    chk(out_port === exp_port, {req, " port"}, 32'(out_port), 32'(exp_port));
    chk(out_data === d && out_ctrl === c, "R9 data", 32'(out_data), 32'(d));
  endtask

  task automatic send_msg(input logic [15:0] dest, input logic [8:0] exp_port, input string req);
    send_tok(dest, 1'b0, exp_port, req);
    chk(route_hold === exp_port, "R8 held", 32'(route_hold), 32'(exp_port));
    send_tok(ME, 1'b0, exp_port, "R9 body");  // looks local, must follow the route
    send_tok(16'h0001, 1'b1, exp_port, "R9 close");
    chk(route_hold === 9'h0, "R8 released", 32'(route_hold), 0);
  endtask

  function automatic logic [15:0] dest_at(input int b);
    logic [15:0] top = 16'(1) << b;
    return ME ^ top ^ ((top - 16'd1) & 16'h5555);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 out_valid", 32'(out_valid), 0);
    chk(route_hold === 9'h0, "R1 route_hold", 32'(route_hold), 0);

    // R2: local delivery
    send_msg(ME, LOCAL, "R2 local");

    // R3/R4: per-bit sweep, direction b%8, single-link masks
    for (int b = 0; b < 16; b++) cfg_write(1'b0, 4'(b), 8'(b % 8));
    for (int d = 0; d < 8; d++) cfg_write(1'b1, 4'(d), 8'(1) << d);
    for (int b = 0; b < 16; b++) send_msg(dest_at(b), 9'(1) << (b % 8), "R3 bit sweep");

    // R5: dir 2 last granted link 2; new set {0,3,6}
    cfg_write(1'b1, 4'd2, 8'b0100_1001);
    send_msg(dest_at(2), 9'(1) << 3, "R5 rr first");
    send_msg(dest_at(2), 9'(1) << 6, "R5 rr second");
    send_msg(dest_at(2), 9'(1) << 0, "R5 rr wrap");
    send_msg(dest_at(2), 9'(1) << 3, "R5 rr again");

    // R6: link 6 busy, skipped
    link_avail = 8'hBF;
    send_msg(dest_at(2), 9'(1) << 0, "R6 skip busy");
    link_avail = 8'hFF;
    send_msg(dest_at(2), 9'(1) << 3, "R6 all free");

    // R7: direction 9 has empty set until written
    cfg_write(1'b0, 4'd15, 8'd9);
    in_valid = 1'b1; in_data = dest_at(15); in_ctrl = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(in_ready === 1'b0, "R7 stall ready", 32'(in_ready), 0);
      @(posedge clk); @(negedge clk);
      chk(out_valid === 1'b0, "R7 stall silent", 32'(out_valid), 0);
    end
    cfg_write(1'b1, 4'd9, 8'h80);
    #1;
    chk(in_ready === 1'b1, "R7 release ready", 32'(in_ready), 1);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1 && out_port === 9'(1) << 7, "R7 released port", 32'(out_port), 32'h80);
    send_tok(16'h1234, 1'b0, 9'(1) << 7, "R9 after stall");
    send_tok(16'h0001, 1'b1, 9'(1) << 7, "R8 close after stall");
    chk(route_hold === 9'h0, "R8 released after stall", 32'(route_hold), 0);

    // R4: direction code >= NDIR has no links
    cfg_write(1'b0, 4'd14, 8'd12);
    in_valid = 1'b1; in_data = dest_at(14); in_ctrl = 1'b0;
    for (int i = 0; i < 2; i++) begin
      #1;
      chk(in_ready === 1'b0, "R4 empty dir", 32'(in_ready), 0);
      @(posedge clk); @(negedge clk);
      chk(out_valid === 1'b0, "R4 empty dir silent", 32'(out_valid), 0);
    end
    in_valid = 1'b0;

    // R8: a control token that is not close keeps the route
    send_tok(dest_at(5), 1'b0, 9'(1) << 5, "R3 hdr");
    send_tok(16'h0002, 1'b1, 9'(1) << 5, "R8 other ctrl");
    chk(route_hold === 9'(1) << 5, "R8 kept", 32'(route_hold), 32'h20);
    send_tok(16'h0001, 1'b1, 9'(1) << 5, "R8 close");
    chk(route_hold === 9'h0, "R8 freed", 32'(route_hold), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule